// File: doc/BRIEF.md
# Framed Byte-Command Register Bridge

This block sits between a byte-wide link receiver and an on-chip register bus. Bytes arrive one at a time under a valid/ready handshake. The block recognises framed commands and turns each read or write command into exactly one access on a simple register bus, which has a chip select, a write enable, an address and separate read and write data words. For every command it then sends back a framed reply, one byte at a time, under a second valid/ready handshake.

Command frames open with 0x55 and close with 0xAA. Reply frames open with 0xAA and close with 0x55. A read command carries an address. A write command carries an address and a data word. A reset command carries nothing and gets a short acknowledgement. Bad frames and unknown opcodes get their own reply codes, so the host can resynchronise. Multi-byte fields travel most-significant byte first. The upper address byte selects a core and the lower byte selects a register inside that core.

Top module: `frame_reg_bridge`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and bus_cs is 0.
- R2: A write frame is 55, 11, two address bytes (high then low), four data bytes (bits 31:24 first, bits 7:0 last), AA. It causes one bus access with bus_we=1 carrying that address and word. The reply is AA, 7E, address high, address low, 55.
- R3: A read frame is 55, 10, address high, address low, AA. It causes one bus access with bus_we=0. bus_rdata is taken in the cycle after bus_cs. The reply is AA, 7F, the two address bytes, the four data bytes (bits 31:24 first), 55.
- R4: A reset frame is 55, 01, AA. It makes no bus access and is answered with AA, 7D, 55.
- R5: Any opcode other than 10, 11 and 01 is answered right after the opcode byte with AA, FE, opcode, 55. No bus access is made.
- R6: A frame whose closing byte is not AA makes no bus access and is answered with AA, FD, opcode, 55.
- R7: While the block waits for a frame, every byte other than 55 is accepted and dropped. It produces no reply and no bus access.
- R8: in_ready is 0 from the moment the closing byte (or the unknown opcode) is accepted until the last reply byte is accepted. While out_valid=1 and out_ready=0, out_valid and out_data hold.
- R9: Each read or write frame produces exactly one bus_cs pulse, one clock long.
- R10: For a read, out_valid first rises exactly two clocks after the bus_cs cycle, that is, after the read data has been latched.
- R11: Every reply starts with AA and ends with 55.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Block can take a command byte |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Receiver takes the reply byte |
| bus_cs | output | 1 | Register bus chip select, one cycle per access |
| bus_we | output | 1 | Register bus write enable, qualified by bus_cs |
| bus_addr | output | 16 | Register address, core in the upper byte |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, valid the cycle after bus_cs |

## Verification
The assertions check several properties on every cycle: the one-cycle chip select, the command input being closed while a reply is pending, reply bytes holding under back-pressure, the opening and closing reply markers, and the gap between a read select and the reply. Only the bench scenarios can show the frame contents. These are the echoed address and data byte order, the reply codes for every unknown opcode, and the error path on a bad closing byte. The scenarios also show that stray bytes between frames are silently dropped, and that rejected frames never reach the bus.

// File: rtl/frame_bridge_pkg.sv
package frame_bridge_pkg;
  localparam logic [7:0] CMD_SOF = 8'h55;
  localparam logic [7:0] CMD_EOF = 8'hAA;
  localparam logic [7:0] RSP_SOF = 8'hAA;
  localparam logic [7:0] RSP_EOF = 8'h55;
  localparam logic [7:0] OP_READ  = 8'h10;
  localparam logic [7:0] OP_WRITE = 8'h11;
  localparam logic [7:0] OP_RESET = 8'h01;
  localparam logic [7:0] RC_READ  = 8'h7F;
  localparam logic [7:0] RC_WRITE = 8'h7E;
  localparam logic [7:0] RC_RESET = 8'h7D;
  localparam logic [7:0] RC_UNK   = 8'hFE;
  localparam logic [7:0] RC_ERR   = 8'hFD;

  typedef enum logic [2:0] {
    CK_READ, CK_WRITE, CK_RESET, CK_UNK, CK_ERR
  } cmd_kind_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_OPC, RX_ADDR, RX_DATA, RX_END, RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/frame_cmd_rx.sv
module frame_cmd_rx
  import frame_bridge_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  input  logic                    release_i,
  output logic                    cmd_vld,
  output cmd_kind_t               cmd_kind,
  output logic [7:0]              cmd_op,
  output logic [ADDR_BYTES*8-1:0] cmd_addr,
  output logic [DATA_BYTES*8-1:0] cmd_wdata
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int DATA_W = DATA_BYTES * 8;
  localparam int CNT_MAX = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
  localparam int CW = $clog2(CNT_MAX + 1);

  rx_state_t          st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [7:0]         op_q, op_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  wd_q, wd_d;
  cmd_kind_t          kind_q, kind_d;
  logic               vld_q, vld_d;
  logic               take;

  assign in_ready = (st_q != RX_HOLD);
  assign take     = in_valid && in_ready;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    kind_d = kind_q;
    vld_d  = 1'b0;
    case (st_q)
      RX_IDLE: if (take && in_data == CMD_SOF) st_d = RX_OPC;
      RX_OPC: if (take) begin
        op_d  = in_data;
        cnt_d = '0;
        if (in_data == OP_READ || in_data == OP_WRITE) st_d = RX_ADDR;
        else if (in_data == OP_RESET)                   st_d = RX_END;
        else begin
          st_d   = RX_HOLD;
          vld_d  = 1'b1;
          kind_d = CK_UNK;
        end
      end
      RX_ADDR: if (take) begin
        addr_d = (addr_q << 8) | ADDR_W'(in_data);
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(ADDR_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = (op_q == OP_WRITE) ? RX_DATA : RX_END;
        end
      end
      RX_DATA: if (take) begin
        wd_d  = (wd_q << 8) | DATA_W'(in_data);
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(DATA_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = RX_END;
        end
      end
      RX_END: if (take) begin
        st_d  = RX_HOLD;
        vld_d = 1'b1;
        if (in_data != CMD_EOF)  kind_d = CK_ERR;
        else if (op_q == OP_READ)  kind_d = CK_READ;
        else if (op_q == OP_WRITE) kind_d = CK_WRITE;
        else                       kind_d = CK_RESET;
      end
      RX_HOLD: if (release_i) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      kind_q <= CK_RESET;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      kind_q <= kind_d;
      vld_q  <= vld_d;
    end
  end

  assign cmd_vld   = vld_q;
  assign cmd_kind  = kind_q;
  assign cmd_op    = op_q;
  assign cmd_addr  = addr_q;
  assign cmd_wdata = wd_q;

  AST_CMD_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> !in_ready) else $error("command issued while input open"); // R8
endmodule

// File: rtl/frame_bus_seq.sv
module frame_bus_seq
  import frame_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_vld,
  input  cmd_kind_t cmd_kind,
  output logic      bus_cs,
  output logic      bus_we,
  output logic      rsp_load
);
  logic rd_wait_q, rd_wait_d;

  assign bus_cs    = cmd_vld && (cmd_kind == CK_READ || cmd_kind == CK_WRITE);
  assign bus_we    = cmd_vld && (cmd_kind == CK_WRITE);
  assign rd_wait_d = cmd_vld && (cmd_kind == CK_READ);
  assign rsp_load  = (cmd_vld && cmd_kind != CK_READ) || rd_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_wait_q <= 1'b0;
    else        rd_wait_q <= rd_wait_d;
  end

  AST_CS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |=> !bus_cs) else $error("chip select longer than one cycle"); // R9
endmodule

// File: rtl/frame_rsp_tx.sv
module frame_rsp_tx
  import frame_bridge_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  cmd_kind_t               kind,
  input  logic [7:0]              op,
  input  logic [ADDR_BYTES*8-1:0] addr,
  input  logic [DATA_BYTES*8-1:0] rdata,
  output logic                    out_valid,
  output logic [7:0]              out_data,
  input  logic                    out_ready,
  output logic                    sent
);
  localparam int FRAME_MAX = 3 + ADDR_BYTES + DATA_BYTES;
  localparam int LW = $clog2(FRAME_MAX + 1);

  logic [7:0]    fr [FRAME_MAX];
  logic [7:0]    buf_q [FRAME_MAX];
  logic [LW-1:0] fr_len, len_q, idx_q, idx_d;
  logic          act_q, act_d;

  always_comb begin
    for (int i = 0; i < FRAME_MAX; i++) fr[i] = 8'h00;
    fr[0]  = RSP_SOF;
    fr_len = LW'(4);
    case (kind)
      CK_READ: begin
        fr[1] = RC_READ;
        for (int i = 0; i < ADDR_BYTES; i++) fr[2+i] = addr[(ADDR_BYTES-1-i)*8 +: 8];
        for (int j = 0; j < DATA_BYTES; j++)
          fr[2+ADDR_BYTES+j] = rdata[(DATA_BYTES-1-j)*8 +: 8];
        fr[FRAME_MAX-1] = RSP_EOF;
        fr_len = LW'(FRAME_MAX);
      end
      CK_WRITE: begin
        fr[1] = RC_WRITE;
        for (int i = 0; i < ADDR_BYTES; i++) fr[2+i] = addr[(ADDR_BYTES-1-i)*8 +: 8];
        fr[2+ADDR_BYTES] = RSP_EOF;
        fr_len = LW'(3 + ADDR_BYTES);
      end
      CK_RESET: begin
        fr[1]  = RC_RESET;
        fr[2]  = RSP_EOF;
        fr_len = LW'(3);
      end
      default: begin
        fr[1] = (kind == CK_UNK) ? RC_UNK : RC_ERR;
        fr[2] = op;
        fr[3] = RSP_EOF;
      end
    endcase
  end

  assign sent = act_q && out_ready && (idx_q == len_q - 1'b1);

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (load) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (sent) begin
      act_d = 1'b0;
    end else if (act_q && out_ready) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      if (load) len_q <= fr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_MAX; i++) buf_q[i] <= 8'h00;
    end else if (load) begin
      for (int i = 0; i < FRAME_MAX; i++) buf_q[i] <= fr[i];
    end
  end

  assign out_valid = act_q;
  assign out_data  = buf_q[idx_q];

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q) else $error("reply loaded over a reply in flight"); // R8
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("reply byte changed under back-pressure"); // R8
  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == RSP_SOF) else $error("bad reply opener"); // R11
  AST_FRAME_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    sent |-> out_data == RSP_EOF) else $error("bad reply closer"); // R11
endmodule

// File: rtl/frame_reg_bridge.sv
module frame_reg_bridge
  import frame_bridge_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int DATA_W = DATA_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              bus_cs,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic        cmd_vld, rsp_load, sent;
  cmd_kind_t   cmd_kind;
  logic [7:0]  cmd_op;

  frame_cmd_rx #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .release_i(sent), .cmd_vld(cmd_vld),
    .cmd_kind(cmd_kind), .cmd_op(cmd_op), .cmd_addr(bus_addr),
    .cmd_wdata(bus_wdata)
  );

  frame_bus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .bus_cs(bus_cs), .bus_we(bus_we), .rsp_load(rsp_load)
  );

  frame_rsp_tx #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(rsp_load), .kind(cmd_kind), .op(cmd_op),
    .addr(bus_addr), .rdata(bus_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .sent(sent)
  );

  AST_INPUT_CLOSED_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready) else $error("input open during reply"); // R8
  AST_READ_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we) |=> !out_valid) else $error("reply before read data"); // R10
endmodule

// File: tb/frame_reg_bridge_test.sv
module frame_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid, out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        bus_cs, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  assign bus_rdata = {bus_addr ^ 16'h5A3C, ~bus_addr};

  frame_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;
  int ncyc = 0, cs_cnt = 0, wr_cnt = 0, cs_cyc = 0, ov_cyc = 0;
  int busy_viol = 0, hold_viol = 0, wide_cs = 0;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic prev_ov = 1'b0, prev_rdy = 1'b1, prev_cs = 1'b0;
  logic [7:0] prev_d = 8'h00;
  logic [7:0] rq[$];
  bit stall = 1'b0;

  always @(negedge clk) if (rst_n) begin
    ncyc++;
    if (bus_cs) begin
      cs_cnt++;
      cs_cyc = ncyc;
      if (prev_cs) wide_cs++;
      if (bus_we) begin wr_cnt++; wr_addr = bus_addr; wr_data = bus_wdata; end
    end
    if (out_valid && !prev_ov) ov_cyc = ncyc;
    if (out_valid && out_ready) rq.push_back(out_data);
    if (out_valid && in_ready) busy_viol++;
    if (prev_ov && !prev_rdy && (!out_valid || out_data != prev_d)) hold_viol++;
    prev_ov = out_valid; prev_rdy = out_ready; prev_d = out_data; prev_cs = bus_cs;
  end

  always @(posedge clk) begin
    #2 out_ready = !stall || (ncyc % 3 == 0);
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_resp(input string req, input logic [7:0] e[9], input int n);
    int k = 0;
    int bad = -1;
    while (rq.size() < n && k < 200) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
    chk(req, "reply length", rq.size(), n);
    for (int i = 0; i < n && i < rq.size(); i++)
      if (bad < 0 && rq[i] !== e[i]) bad = i;
    if (bad >= 0) chk(req, $sformatf("reply byte %0d", bad), rq[bad], e[bad]);
    else chk(req, "reply bytes", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] e[9];
    int cs0, wr0;
    repeat (3) @(negedge clk);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "bus_cs", bus_cs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after release", in_ready, 1);

    // R7: stray bytes dropped, then a reset frame answers alone
    rq.delete(); cs0 = cs_cnt;
    send_byte(8'h00); send_byte(8'h12); send_byte(8'hAA); send_byte(8'hFF); send_byte(8'h7F);
    repeat (6) @(negedge clk);
    chk("R7", "no reply to stray bytes", rq.size(), 0);
    chk("R7", "no access on stray bytes", cs_cnt - cs0, 0);
    send_byte(8'h55); send_byte(8'h01); send_byte(8'hAA);
    e = '{8'hAA, 8'h7D, 8'h55, 0, 0, 0, 0, 0, 0};
    expect_resp("R4", e, 3);
    chk("R4", "no access on reset", cs_cnt - cs0, 0);

    // R5: every unknown opcode
    cs0 = cs_cnt;
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h10 || op == 8'h11 || op == 8'h01) continue;
      rq.delete();
      stall = (op % 5 == 0);
      send_byte(8'h55); send_byte(8'(op));
      e = '{8'hAA, 8'hFE, 8'(op), 8'h55, 0, 0, 0, 0, 0};
      expect_resp("R5", e, 4);
    end
    stall = 1'b0;
    chk("R5", "no access on unknown opcodes", cs_cnt - cs0, 0);

    // R6: bad closing byte on each command type
    cs0 = cs_cnt;
    rq.delete();
    send_byte(8'h55); send_byte(8'h01); send_byte(8'h00);
    e = '{8'hAA, 8'hFD, 8'h01, 8'h55, 0, 0, 0, 0, 0};
    expect_resp("R6", e, 4);
    rq.delete();
    send_byte(8'h55); send_byte(8'h10); send_byte(8'h12); send_byte(8'h34); send_byte(8'h55);
    e = '{8'hAA, 8'hFD, 8'h10, 8'h55, 0, 0, 0, 0, 0};
    expect_resp("R6", e, 4);
    rq.delete();
    send_byte(8'h55); send_byte(8'h11); send_byte(8'h01); send_byte(8'h02);
    send_byte(8'h03); send_byte(8'h04); send_byte(8'h05); send_byte(8'h06); send_byte(8'hAB);
    e = '{8'hAA, 8'hFD, 8'h11, 8'h55, 0, 0, 0, 0, 0};
    expect_resp("R6", e, 4);
    chk("R6", "no access on bad frames", cs_cnt - cs0, 0);

    // R2: writes over a sweep of addresses and words
    for (int i = 0; i < 32; i++) begin
      logic [15:0] a = 16'(i * 16'h0811) ^ 16'h2040;
      logic [31:0] d = 32'(i) * 32'h01030507 + 32'h8000_0001;
      rq.delete(); cs0 = cs_cnt; wr0 = wr_cnt;
      stall = i[0];
      send_byte(8'h55); send_byte(8'h11); send_byte(a[15:8]); send_byte(a[7:0]);
      send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
      send_byte(8'hAA);
      e = '{8'hAA, 8'h7E, a[15:8], a[7:0], 8'h55, 0, 0, 0, 0};
      expect_resp("R2", e, 5);
      chk("R9", "one access per write", cs_cnt - cs0, 1);
      chk("R2", "write strobe count", wr_cnt - wr0, 1);
      chk("R2", "write address", wr_addr, a);
      chk("R2", "write data", wr_data, d);
    end

    // R3: reads, data pattern computed from address
    for (int i = 0; i < 32; i++) begin
      logic [15:0] a = 16'(i * 16'h1357) ^ 16'h0F0F;
      logic [31:0] d = {a ^ 16'h5A3C, ~a};
      rq.delete(); cs0 = cs_cnt; wr0 = wr_cnt;
      stall = i[1];
      send_byte(8'h55); send_byte(8'h10); send_byte(a[15:8]); send_byte(a[7:0]);
      send_byte(8'hAA);
      e = '{8'hAA, 8'h7F, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], 8'h55};
      expect_resp("R3", e, 9);
      chk("R9", "one access per read", cs_cnt - cs0, 1);
      chk("R3", "no write strobe on read", wr_cnt - wr0, 0);
      chk("R10", "select to reply gap", ov_cyc - cs_cyc, 2);
    end
    stall = 1'b0;

    chk("R8", "input open during reply", busy_viol, 0);
    chk("R8", "reply changed under stall", hold_viol, 0);
    chk("R9", "select wider than one cycle", wide_cs, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule